// File: doc/BRIEF.md
# Serial Accumulator Arithmetic Unit

This block is the arithmetic core of a bit-serial machine. It holds a 32-bit two's-complement accumulator and changes it one bit per bit-clock enable, so that a whole word operation fills a frame of 32 enabled cycles. A frame opens with a word-start strobe. The operand arrives on a single serial input, least significant bit first. Each freshly produced accumulator bit appears on a serial result output in the same cycle. A single carry flip-flop joins the bit positions of a frame, so there is no parallel adder.

The unit loads, adds, subtracts, shifts arithmetically to the right and rotates to the right. A shift or rotate by n positions occupies n back-to-back frames, one position per frame. While such a command still has frames to run, a busy output is high and the command inputs are ignored. At the end of every frame the unit latches sign and zero flags from the finished word. A branch decision elsewhere in the processor can test these flags. Overflow wraps with no indication.

Top module: `serial_acc_unit`

## Requirements
- R1: A frame opens on a cycle with both `word_start` and `bit_en` high while no frame is open, and it spans exactly 32 `bit_en` cycles. `res_valid` is high on each of them. `word_done` is high on the 32nd. Bit k of the operand and of the result travels on the k-th enabled cycle, LSB first.
- R2: Opcode 1 (load) replaces the accumulator with the serial operand word.
- R3: Opcode 2 (add) replaces the accumulator with accumulator plus operand, modulo 2^32.
- R4: Opcode 3 (subtract) replaces the accumulator with accumulator minus operand, modulo 2^32.
- R5: Opcode 4 with `shift_amt` = n > 0 runs n frames. Each frame shifts the accumulator right by one and copies bit 31 into bit 31.
- R6: Opcode 5 with `shift_amt` = n > 0 runs n frames. Each frame rotates the accumulator right by one, so bit 0 moves into bit 31.
- R7: Opcode 4 or 5 with `shift_amt` = 0 runs one frame and leaves the accumulator unchanged.
- R8: `busy_o` is high from the opening of a command's first frame until its last frame closes. At frames that open while it is high, `op_code`, `shift_amt` and `opnd_bit` are ignored.
- R9: When a frame closes, `sign_o` takes bit 31 of the new accumulator and `zero_o` is set when the new accumulator is 0. Both flags hold their values at all other times.
- R10: Opcodes 0, 6 and 7 leave the accumulator unchanged and stream its current value out on `res_bit`.
- R11: Cycles with `bit_en` low stall a frame and change nothing. `bit_en` pulses with no open frame and no `word_start` leave the accumulator unchanged.
- R12: After reset the accumulator is 0, `sign_o` is 0, `zero_o` is 1 and `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-clock enable; one bit operation per high cycle |
| word_start | input | 1 | Opens a frame together with `bit_en` |
| op_code | input | 3 | Operation selected at the opening of a command |
| shift_amt | input | 5 | Positions for shift and rotate |
| opnd_bit | input | 1 | Serial operand bit, LSB first |
| res_bit | output | 1 | New accumulator bit of this step |
| res_valid | output | 1 | `res_bit` is valid this cycle |
| word_done | output | 1 | Last bit step of a frame |
| busy_o | output | 1 | A command is still in progress |
| sign_o | output | 1 | Sign of the accumulator after the last frame |
| zero_o | output | 1 | Accumulator was zero after the last frame |

## Verification
Carry chains are run through operands that ripple a carry across sixteen bit positions, wrap from the largest positive value into the negative range, and cancel to exactly zero. These patterns separate a carry held from step to step from one that is lost or reset between bits. Subtraction is tried with a zero operand and with equal operands, which exposes a missing carry preset or a missing operand inversion. Shifts and rotates run over several frames on negative and positive words, with unrelated commands offered at the continuing frames, so that sign fill differs from zero fill and the wrapped bit 0 differs from a copied bit 31. Frames with enable gaps and enable pulses outside any frame show that only enabled steps inside a frame move the accumulator.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_LOAD = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_SRA  = 3'd4,
    OP_ROR  = 3'd5
  } sacc_op_e;

  // Map a raw code to a command; a zero-position shift becomes a hold.
  function automatic sacc_op_e sacc_decode(input logic [2:0] code, input logic amt_zero);
    sacc_op_e r;
    case (code)
      3'd1:    r = OP_LOAD;
      3'd2:    r = OP_ADD;
      3'd3:    r = OP_SUB;
      3'd4:    r = amt_zero ? OP_HOLD : OP_SRA;
      3'd5:    r = amt_zero ? OP_HOLD : OP_ROR;
      default: r = OP_HOLD;
    endcase
    return r;
  endfunction

  function automatic logic sacc_is_shift(input sacc_op_e op);
    return (op == OP_SRA) || (op == OP_ROR);
  endfunction

  // Carry value that enters bit 0 of a frame.
  function automatic logic sacc_carry_seed(input sacc_op_e op);
    return (op == OP_SUB);
  endfunction

  // One bit step. a0 is the accumulator bit at this position, a1 the next
  // higher one. Returns {carry_out, new_bit}.
  function automatic logic [1:0] sacc_bit_step(input sacc_op_e op, input logic a0,
                                              input logic a1, input logic b,
                                              input logic cin, input logic first,
                                              input logic last);
    logic nb;
    logic co;
    logic bx;
    nb = a0;
    co = cin;
    bx = (op == OP_SUB) ? ~b : b;
    case (op)
      OP_LOAD: nb = b;
      OP_ADD, OP_SUB: begin
        nb = a0 ^ bx ^ cin;
        co = (a0 & bx) | (a0 & cin) | (bx & cin);
      end
      OP_SRA: nb = last ? a0 : a1;
      OP_ROR: begin
        nb = last ? cin : a1;
        co = first ? a0 : cin;
      end
      default: nb = a0;
    endcase
    return {co, nb};
  endfunction

endpackage

// File: rtl/sacc_sequencer.sv
module sacc_sequencer
  import sacc_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int IDXW = $clog2(WIDTH),
  localparam int REPW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            word_start,
  input  logic [2:0]      op_code,
  input  logic [IDXW-1:0] shift_amt,
  output logic            step,
  output logic            first,
  output logic            last,
  output sacc_op_e        eff_cmd,
  output sacc_op_e        cmd_q,
  output logic            busy
);

  logic            in_frame_q;
  logic [IDXW-1:0] idx_q;
  logic [REPW-1:0] reps_q;
  logic            fresh;
  sacc_op_e        new_cmd;
  logic [REPW-1:0] new_reps;

  assign step    = bit_en & (in_frame_q | word_start);
  assign first   = step & ~in_frame_q;
  assign last    = step & in_frame_q & (idx_q == IDXW'(WIDTH - 1));
  assign fresh   = first & (reps_q == '0);
  assign new_cmd = sacc_decode(op_code, shift_amt == '0);
  assign eff_cmd = fresh ? new_cmd : cmd_q;
  assign new_reps = sacc_is_shift(new_cmd) ? REPW'(shift_amt) : REPW'(1);
  assign busy    = (reps_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      idx_q      <= '0;
    end else if (first) begin
      in_frame_q <= 1'b1;
      idx_q      <= IDXW'(1);
    end else if (last) begin
      in_frame_q <= 1'b0;
      idx_q      <= '0;
    end else if (step) begin
      idx_q      <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reps_q <= '0;
      cmd_q  <= OP_HOLD;
    end else if (fresh) begin
      reps_q <= new_reps;
      cmd_q  <= new_cmd;
    end else if (last) begin
      reps_q <= reps_q - 1'b1;
    end
  end

endmodule

// File: rtl/sacc_bit_alu.sv
module sacc_bit_alu
  import sacc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  input  logic     first,
  input  logic     last,
  input  sacc_op_e cmd,
  input  logic     a0,
  input  logic     a1,
  input  logic     opnd,
  output logic     new_bit
);

  logic       carry_q;
  logic       cin;
  logic [1:0] res;

  assign cin     = first ? sacc_carry_seed(cmd) : carry_q;
  assign res     = sacc_bit_step(cmd, a0, a1, opnd, cin, first, last);
  assign new_bit = res[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    carry_q <= 1'b0;
    else if (step) carry_q <= res[1];
  end

endmodule

// File: rtl/sacc_acc_reg.sv
module sacc_acc_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             first,
  input  logic             last,
  input  logic             new_bit,
  output logic [WIDTH-1:0] acc_q,
  output logic             a0,
  output logic             a1,
  output logic             sign_o,
  output logic             zero_o
);

  logic nz_q;

  assign a0 = acc_q[0];
  assign a1 = acc_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      nz_q  <= 1'b0;
    end else if (step) begin
      acc_q <= {new_bit, acc_q[WIDTH-1:1]};
      nz_q  <= first ? new_bit : (nz_q | new_bit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_o <= 1'b0;
      zero_o <= 1'b1;
    end else if (last) begin
      sign_o <= new_bit;
      zero_o <= ~(nz_q | new_bit);
    end
  end

endmodule

// File: rtl/serial_acc_unit.sv
module serial_acc_unit
  import sacc_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_en,
  input  logic           word_start,
  input  logic [2:0]     op_code,
  input  logic [SHW-1:0] shift_amt,
  input  logic           opnd_bit,
  output logic           res_bit,
  output logic           res_valid,
  output logic           word_done,
  output logic           busy_o,
  output logic           sign_o,
  output logic           zero_o
);

  logic             step_w;
  logic             frame_begin;
  logic             frame_end;
  sacc_op_e         eff_cmd;
  sacc_op_e         cmd_q;
  logic             a0_w;
  logic             a1_w;
  logic             nb_w;
  logic [WIDTH-1:0] acc_w;

  sacc_sequencer #(.WIDTH(WIDTH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .word_start (word_start),
    .op_code    (op_code),
    .shift_amt  (shift_amt),
    .step       (step_w),
    .first      (frame_begin),
    .last       (frame_end),
    .eff_cmd    (eff_cmd),
    .cmd_q      (cmd_q),
    .busy       (busy_o)
  );

  sacc_bit_alu u_alu (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step_w),
    .first   (frame_begin),
    .last    (frame_end),
    .cmd     (eff_cmd),
    .a0      (a0_w),
    .a1      (a1_w),
    .opnd    (opnd_bit),
    .new_bit (nb_w)
  );

  sacc_acc_reg #(.WIDTH(WIDTH)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step_w),
    .first   (frame_begin),
    .last    (frame_end),
    .new_bit (nb_w),
    .acc_q   (acc_w),
    .a0      (a0_w),
    .a1      (a1_w),
    .sign_o  (sign_o),
    .zero_o  (zero_o)
  );

  assign res_bit   = nb_w;
  assign res_valid = step_w;
  assign word_done = frame_end;

endmodule

// File: rtl/sacc_checker.sv
module sacc_checker #(
  parameter int WIDTH = 32,
  localparam int CW = $clog2(WIDTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic             frame_begin,
  input logic             word_done,
  input logic [WIDTH-1:0] acc_q,
  input logic [2:0]       cmd_q,
  input logic             busy_o,
  input logic             sign_o,
  input logic             zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (frame_begin) cnt_q <= CW'(1);
    else if (step)        cnt_q <= cnt_q + 1'b1;
  end

  assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (cnt_q == CW'(WIDTH - 1)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(acc_q));

  assert_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> ((zero_o == (acc_q == '0)) && (sign_o == acc_q[WIDTH-1])));

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |=> ($stable(sign_o) && $stable(zero_o)));

  assert_cmd_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_begin && busy_o) |=> $stable(cmd_q));

  assert_busy_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !frame_begin) |-> busy_o);

endmodule

bind serial_acc_unit sacc_checker #(.WIDTH(WIDTH)) u_sacc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step        (step_w),
  .frame_begin (frame_begin),
  .word_done   (word_done),
  .acc_q       (acc_w),
  .cmd_q       (cmd_q),
  .busy_o      (busy_o),
  .sign_o      (sign_o),
  .zero_o      (zero_o)
);

// File: tb/serial_acc_unit_test.sv
module serial_acc_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       word_start = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [4:0] shift_amt = 5'd0;
  logic       opnd_bit = 1'b0;
  logic       res_bit, res_valid, word_done, busy_o, sign_o, zero_o;

  always #2 clk = ~clk;

  serial_acc_unit uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_start(word_start),
    .op_code(op_code), .shift_amt(shift_amt), .opnd_bit(opnd_bit),
    .res_bit(res_bit), .res_valid(res_valid), .word_done(word_done),
    .busy_o(busy_o), .sign_o(sign_o), .zero_o(zero_o)
  );

  typedef struct {
    logic [31:0] w;
    logic        s;
    logic        z;
    logic        b;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [31:0] model = 32'd0;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w, input logic bsy, input string tag);
    exp_t e;
    e.w = w; e.s = w[31]; e.z = (w == 32'd0); e.b = bsy; e.tag = tag;
    q.push_back(e);
    model = w;
  endtask

  task automatic send_frame(input logic [2:0] op, input logic [4:0] amt,
                            input logic [31:0] data, input int gap);
    for (int i = 0; i < 32; i++) begin
      @(posedge clk); #1;
      bit_en = 1'b1; word_start = (i == 0); op_code = op; shift_amt = amt;
      opnd_bit = data[i];
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1;
        bit_en = 1'b0; word_start = 1'b0; opnd_bit = ~data[i];
      end
    end
    @(posedge clk); #1;
    bit_en = 1'b0; word_start = 1'b0; op_code = 3'd1; opnd_bit = 1'b1;
  endtask

  task automatic do_op(input logic [2:0] op, input logic [31:0] d, input string tag,
                       input int gap);
    logic [31:0] r;
    case (op)
      3'd1:    r = d;
      3'd2:    r = model + d;
      3'd3:    r = model - d;
      default: r = model;
    endcase
    push(r, 1'b0, tag);
    send_frame(op, 5'd0, d, gap);
  endtask

  // Shift (op 4) or rotate (op 5); later frames offer an unrelated load.
  task automatic do_shift(input logic [2:0] op, input int n, input string tag);
    logic [31:0] r;
    if (n == 0) begin
      push(model, 1'b0, tag);
      send_frame(op, 5'd0, 32'hA5A5_5A5A, 0);
    end else begin
      for (int k = 0; k < n; k++) begin
        r = (op == 3'd4) ? {model[31], model[31:1]} : {model[0], model[31:1]};
        push(r, (k < n - 1), tag);
        if (k == 0) send_frame(op, 5'(n), 32'h1357_9BDF, 0);
        else        send_frame(3'd1, 5'd1, 32'hDEAD_BEEF, 0);
      end
    end
  endtask

  // Monitor: collects serial result bits and compares with the scoreboard.
  int          bidx = 0;
  logic [31:0] got = 32'd0;
  bit          pend = 1'b0;
  exp_t        cur;

  always @(negedge clk) begin
    if (pend) begin
      pend = 1'b0;
      check(sign_o == cur.s, {cur.tag, " R9 sign"}, 32'(sign_o), 32'(cur.s));
      check(zero_o == cur.z, {cur.tag, " R9 zero"}, 32'(zero_o), 32'(cur.z));
      check(busy_o == cur.b, {cur.tag, " R8 busy"}, 32'(busy_o), 32'(cur.b));
    end
    if (rst_n && res_valid) begin
      got[bidx[4:0]] = res_bit;
      if (word_done) begin
        check(bidx == 31, "R1 frame length", 32'(bidx), 32'd31);
        if (q.size() == 0) begin
          check(1'b0, "R1 unexpected frame", got, 32'd0);
        end else begin
          cur = q.pop_front();
          check(got == cur.w, {cur.tag, " word"}, got, cur.w);
          pend = 1'b1;
        end
        bidx = 0;
      end else begin
        bidx++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(sign_o == 1'b0, "R12 sign", 32'(sign_o), 32'd0);
    check(zero_o == 1'b1, "R12 zero", 32'(zero_o), 32'd1);
    check(busy_o == 1'b0, "R12 busy", 32'(busy_o), 32'd0);
    do_op(3'd0, 32'hFFFF_FFFF, "R12 acc", 0);

    // Enable pulses with no frame open
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      bit_en = i[0]; word_start = 1'b0; op_code = 3'd1; opnd_bit = 1'b1;
    end
    @(posedge clk); #1 bit_en = 1'b0;
    do_op(3'd0, 32'h0, "R11 idle", 0);

    do_op(3'd1, 32'h1234_5678, "R2 load", 0);
    do_op(3'd6, 32'hFFFF_0000, "R10 op6", 0);
    do_op(3'd7, 32'h0F0F_0F0F, "R10 op7", 0);
    do_op(3'd0, 32'h8000_0001, "R11 stall", 2);
    do_op(3'd1, 32'h0000_FFFF, "R2 load", 0);
    do_op(3'd2, 32'h0000_0001, "R3 ripple", 0);
    do_op(3'd1, 32'h7FFF_FFFF, "R2 load", 0);
    do_op(3'd2, 32'h0000_0001, "R3 wrap", 0);
    do_op(3'd2, 32'h8000_0000, "R3 zero", 0);
    do_op(3'd2, 32'h9ABC_DEF1, "R3 gaps R11", 1);
    do_op(3'd1, 32'h0000_0005, "R2 load", 0);
    do_op(3'd3, 32'h0000_0007, "R4 negative", 0);
    do_op(3'd3, 32'hFFFF_FFFE, "R4 equal", 0);
    do_op(3'd1, 32'h8000_0000, "R2 load", 0);
    do_op(3'd3, 32'h0000_0000, "R4 zero opnd", 0);
    do_op(3'd3, 32'h0000_0001, "R4 wrap", 0);
    do_op(3'd1, 32'h8000_0010, "R2 load", 0);
    do_shift(3'd4, 3, "R5 neg R8");
    do_op(3'd1, 32'h4000_0000, "R2 load", 0);
    do_shift(3'd4, 2, "R5 pos");
    do_op(3'd1, 32'hF000_0001, "R2 load", 0);
    do_shift(3'd5, 4, "R6 ror R8");
    do_shift(3'd5, 31, "R6 ror31");
    do_shift(3'd4, 0, "R7 sra0");
    do_shift(3'd5, 0, "R7 ror0");

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(q.size() == 0, "R1 queue drained", 32'(q.size()), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule